// File: doc/BRIEF.md
# Boot-Remap AHB Address Decoder

This block is the address decoder of a small microcontroller AHB fabric. Each transfer goes to one of three targets: a non-volatile boot ROM, a fast SRAM, or a built-in default slave that answers unmapped addresses. The choice comes from the upper bits of the address and from a one-bit remap register. Out of reset the low region holds the reset vector and routes to the boot ROM, so the CPU's first instruction fetch reaches the boot code. When software sets the remap bit, the low region routes to SRAM instead. The ROM can then still be reached through its alias region.

The select lines are combinational from the address phase. The target that won the address phase is captured in a data-phase register. That register steers read data, ready and response back to the master, and it is held for as long as the addressed slave keeps the bus stalled. The remap bit is written through a sideband enable/data pair and only changes at a transfer boundary. Leaving it clear is a valid way to run the whole system from the ROM mapping.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, `hready` is 1 and `hresp` is 0 (OKAY). The data-phase target resets to the default slave.
- R2: While the remap bit is 0 (its reset value), an address whose bits [31:16] equal 0x0000 raises `hsel_rom`.
- R3: While the remap bit is 1, an address whose bits [31:16] equal 0x0000 raises `hsel_sram`.
- R4: An address whose bits [31:16] equal 0x1000 (the ROM alias) raises `hsel_rom` whatever the remap bit holds.
- R5: An address whose bits [31:16] equal 0x2000 raises `hsel_sram` whatever the remap bit holds.
- R6: Any other address raises `hsel_def`. A NONSEQ (`htrans`=2'b10) or SEQ (2'b11) transfer to it gets a two-cycle ERROR: first `hready`=0 with `hresp`=1, then `hready`=1 with `hresp`=1.
- R7: An IDLE (2'b00) or BUSY (2'b01) transfer to the default slave completes with zero wait states and OKAY.
- R8: Exactly one of `hsel_rom`, `hsel_sram`, `hsel_def` is high in every cycle.
- R9: `hrdata`, `hready` and `hresp` follow the slave chosen in the address phase. That choice is held through data-phase wait states, so the ready of other slaves has no effect.
- R10: A remap write (`remap_we`=1) is accepted only in a cycle where `hready` is 1. A write during a wait state is ignored.
- R11: Writing 0 to the remap bit returns the low region to the boot ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type (00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ) |
| remap_we | input | 1 | Remap bit write enable |
| remap_wdata | input | 1 | Remap bit write value |
| hsel_rom | output | 1 | Boot ROM select |
| hsel_sram | output | 1 | SRAM select |
| hsel_def | output | 1 | Default slave select (for observation) |
| rom_rdata | input | 32 | ROM read data |
| rom_readyout | input | 1 | ROM ready |
| rom_resp | input | 1 | ROM response (1 = ERROR) |
| sram_rdata | input | 32 | SRAM read data |
| sram_readyout | input | 1 | SRAM ready |
| sram_resp | input | 1 | SRAM response (1 = ERROR) |
| hrdata | output | 32 | Read data to master |
| hready | output | 1 | Ready to master and slaves |
| hresp | output | 1 | Response to master (1 = ERROR) |

## Verification
A remap write and a stalled data phase can fall in the same cycle. The bench sets up this collision by asserting `remap_we` while a ROM fetch has `rom_readyout` low. After the stall ends, it judges the outcome by checking that the low region still raises `hsel_rom`. A second collision is a new address phase decoded to SRAM while the ROM data phase is still waiting. Here `hready` must keep following the ROM's ready and must not follow the SRAM's, which is held high throughout.

// File: rtl/brd_pkg.sv
package brd_pkg;
    typedef enum logic [1:0] {
        TGT_ROM  = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_DEF  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_ERR1 = 2'd1,
        DS_ERR2 = 2'd2
    } dstate_e;

    localparam int NUM_TGT = 3;
endpackage

// File: rtl/brd_addr_decode.sv
module brd_addr_decode
    import brd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 16,
    parameter logic [ADDR_W-REGION_BITS-1:0] LOW_TAG   = '0,
    parameter logic [ADDR_W-REGION_BITS-1:0] ALIAS_TAG = 16'h1000,
    parameter logic [ADDR_W-REGION_BITS-1:0] SRAM_TAG  = 16'h2000
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               remap,
    output tgt_e               tgt,
    output logic [NUM_TGT-1:0] sel
);
    localparam int TAG_W = ADDR_W - REGION_BITS;

    logic [TAG_W-1:0] tag;
    assign tag = addr[ADDR_W-1:REGION_BITS];

    always_comb begin
        tgt = TGT_DEF;
        if (tag == LOW_TAG) begin
            tgt = remap ? TGT_SRAM : TGT_ROM;
        end else if (tag == ALIAS_TAG) begin
            tgt = TGT_ROM;
        end else if (tag == SRAM_TAG) begin
            tgt = TGT_SRAM;
        end
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign sel[g] = (tgt == tgt_e'(g));
    end
endmodule

// File: rtl/brd_remap_reg.sv
module brd_remap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    input  logic bus_ready,
    output logic remap
);
    typedef struct packed {
        logic remap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && bus_ready) begin
            st_d.remap = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remap = st_q.remap;
endmodule

// File: rtl/brd_default_slave.sv
module brd_default_slave
    import brd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [1:0] htrans,
    input  logic       bus_ready,
    output logic       ready_out,
    output logic       resp_out
);
    typedef struct packed {
        dstate_e state;
    } st_t;

    st_t st_d, st_q;
    logic active_xfer;

    assign active_xfer = sel && bus_ready && htrans[1];

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            DS_ERR1: st_d.state = DS_ERR2;
            DS_IDLE, DS_ERR2: st_d.state = active_xfer ? DS_ERR1 : DS_IDLE;
            default: st_d.state = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= DS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_out = (st_q.state != DS_ERR1);
    assign resp_out  = (st_q.state != DS_IDLE);
endmodule

// File: rtl/brd_resp_mux.sv
module brd_resp_mux
    import brd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              addr_tgt,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              rom_ready,
    input  logic              rom_resp,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic              sram_ready,
    input  logic              sram_resp,
    input  logic              def_ready,
    input  logic              def_resp,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              resp,
    output tgt_e              data_tgt
);
    typedef struct packed {
        tgt_e tgt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        rdata = '0;
        ready = def_ready;
        resp  = def_resp;
        unique case (st_q.tgt)
            TGT_ROM: begin
                rdata = rom_rdata;
                ready = rom_ready;
                resp  = rom_resp;
            end
            TGT_SRAM: begin
                rdata = sram_rdata;
                ready = sram_ready;
                resp  = sram_resp;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ready) begin
            st_d.tgt = addr_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tgt <= TGT_DEF;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_tgt = st_q.tgt;
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import brd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int REGION_BITS = 16,
    parameter logic [ADDR_W-REGION_BITS-1:0] LOW_TAG   = '0,
    parameter logic [ADDR_W-REGION_BITS-1:0] ALIAS_TAG = 16'h1000,
    parameter logic [ADDR_W-REGION_BITS-1:0] SRAM_TAG  = 16'h2000
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              remap_we,
    input  logic              remap_wdata,
    output logic              hsel_rom,
    output logic              hsel_sram,
    output logic              hsel_def,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic              rom_readyout,
    input  logic              rom_resp,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic              sram_readyout,
    input  logic              sram_resp,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              hresp
);
    tgt_e               addr_tgt;
    tgt_e               data_tgt;
    logic [NUM_TGT-1:0] sel_vec;
    logic               remap_on;
    logic               def_ready;
    logic               def_resp;

    brd_remap_reg u_remap (
        .clk       (hclk),
        .rst_n     (hresetn),
        .we        (remap_we),
        .wdata     (remap_wdata),
        .bus_ready (hready),
        .remap     (remap_on)
    );

    brd_addr_decode #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS),
        .LOW_TAG     (LOW_TAG),
        .ALIAS_TAG   (ALIAS_TAG),
        .SRAM_TAG    (SRAM_TAG)
    ) u_dec (
        .addr  (haddr),
        .remap (remap_on),
        .tgt   (addr_tgt),
        .sel   (sel_vec)
    );

    assign hsel_rom  = sel_vec[TGT_ROM];
    assign hsel_sram = sel_vec[TGT_SRAM];
    assign hsel_def  = sel_vec[TGT_DEF];

    brd_default_slave u_def (
        .clk       (hclk),
        .rst_n     (hresetn),
        .sel       (hsel_def),
        .htrans    (htrans),
        .bus_ready (hready),
        .ready_out (def_ready),
        .resp_out  (def_resp)
    );

    brd_resp_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .clk        (hclk),
        .rst_n      (hresetn),
        .addr_tgt   (addr_tgt),
        .rom_rdata  (rom_rdata),
        .rom_ready  (rom_readyout),
        .rom_resp   (rom_resp),
        .sram_rdata (sram_rdata),
        .sram_ready (sram_readyout),
        .sram_resp  (sram_resp),
        .def_ready  (def_ready),
        .def_resp   (def_resp),
        .rdata      (hrdata),
        .ready      (hready),
        .resp       (hresp),
        .data_tgt   (data_tgt)
    );
endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk
    import brd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 16,
    parameter logic [ADDR_W-REGION_BITS-1:0] LOW_TAG   = '0,
    parameter logic [ADDR_W-REGION_BITS-1:0] ALIAS_TAG = 16'h1000,
    parameter logic [ADDR_W-REGION_BITS-1:0] SRAM_TAG  = 16'h2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] haddr,
    input logic              hsel_rom,
    input logic              hsel_sram,
    input logic              hsel_def,
    input logic              hready,
    input logic              hresp,
    input logic              remap_on,
    input tgt_e              data_tgt
);
    logic is_low, is_alias, is_sram;
    assign is_low   = haddr[ADDR_W-1:REGION_BITS] == LOW_TAG;
    assign is_alias = haddr[ADDR_W-1:REGION_BITS] == ALIAS_TAG;
    assign is_sram  = haddr[ADDR_W-1:REGION_BITS] == SRAM_TAG;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hsel_rom, hsel_sram, hsel_def}) == 1); // R8

    AST_BOOT_LOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (is_low && !remap_on) |-> hsel_rom); // R2

    AST_REMAP_LOW_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (is_low && remap_on) |-> hsel_sram); // R3

    AST_ALIAS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        is_alias |-> hsel_rom); // R4

    AST_SRAM_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        is_sram |-> hsel_sram); // R5

    AST_DATA_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(data_tgt)); // R9

    AST_REMAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(remap_on)); // R10

    AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && hresp && data_tgt == TGT_DEF) |=> (hready && hresp)); // R6
endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .REGION_BITS (REGION_BITS),
    .LOW_TAG     (LOW_TAG),
    .ALIAS_TAG   (ALIAS_TAG),
    .SRAM_TAG    (SRAM_TAG)
) u_chk (
    .clk       (hclk),
    .rst_n     (hresetn),
    .haddr     (haddr),
    .hsel_rom  (hsel_rom),
    .hsel_sram (hsel_sram),
    .hsel_def  (hsel_def),
    .hready    (hready),
    .hresp     (hresp),
    .remap_on  (remap_on),
    .data_tgt  (data_tgt)
);

// File: tb/tb_boot_remap_decoder.sv
`timescale 1ns/1ps
module tb_boot_remap_decoder;
    logic        hclk = 1'b0;
    logic        hresetn;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        remap_we, remap_wdata;
    logic        hsel_rom, hsel_sram, hsel_def;
    logic [31:0] rom_rdata, sram_rdata, hrdata;
    logic        rom_readyout, rom_resp, sram_readyout, sram_resp;
    logic        hready, hresp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

    always #5 hclk = ~hclk;

    boot_remap_decoder dut (
        .hclk(hclk), .hresetn(hresetn), .haddr(haddr), .htrans(htrans),
        .remap_we(remap_we), .remap_wdata(remap_wdata),
        .hsel_rom(hsel_rom), .hsel_sram(hsel_sram), .hsel_def(hsel_def),
        .rom_rdata(rom_rdata), .rom_readyout(rom_readyout), .rom_resp(rom_resp),
        .sram_rdata(sram_rdata), .sram_readyout(sram_readyout), .sram_resp(sram_resp),
        .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic sel_is(input string req, input logic [2:0] exp_rsd);
        chk(req, "hsel {rom,sram,def}", {29'd0, hsel_rom, hsel_sram, hsel_def}, {29'd0, exp_rsd});
        chk("R8", "one-hot select", {31'd0, ($countones({hsel_rom, hsel_sram, hsel_def}) == 1)}, 32'd1);
    endtask

    task automatic step();
        @(negedge hclk);
    endtask

    task automatic t_reset();
        hresetn = 1'b0; haddr = 32'h0; htrans = T_IDLE;
        remap_we = 1'b0; remap_wdata = 1'b0;
        rom_rdata = 32'h0; rom_readyout = 1'b1; rom_resp = 1'b0;
        sram_rdata = 32'h0; sram_readyout = 1'b1; sram_resp = 1'b0;
        repeat (3) step();
        #1;
        chk("R1", "hready in reset", {31'd0, hready}, 32'd1);
        chk("R1", "hresp in reset", {31'd0, hresp}, 32'd0);
        hresetn = 1'b1;
        step(); #1;
        chk("R1", "hready after reset", {31'd0, hready}, 32'd1);
        chk("R1", "hresp after reset", {31'd0, hresp}, 32'd0);
    endtask

    // First fetch at the reset vector, ROM inserts two wait states.
    task automatic t_boot_fetch();
        step(); haddr = 32'h0000_0000; htrans = T_NSEQ; #1;
        sel_is("R2", 3'b100);
        step(); haddr = 32'h2000_0040; htrans = T_IDLE; rom_readyout = 1'b0;
        rom_rdata = 32'hDEAD_0000; sram_rdata = 32'h5555_AAAA; #1;
        chk("R9", "wait state 1 hready", {31'd0, hready}, 32'd0);
        step(); #1;
        chk("R9", "wait state 2 hready (sram ready ignored)", {31'd0, hready}, 32'd0);
        step(); rom_readyout = 1'b1; rom_rdata = 32'hB007_0001; #1;
        chk("R9", "fetch done hready", {31'd0, hready}, 32'd1);
        chk("R9", "fetch data", hrdata, 32'hB007_0001);
        chk("R9", "fetch resp", {31'd0, hresp}, 32'd0);
        step(); htrans = T_IDLE; #1;
        chk("R9", "sram data phase data", hrdata, 32'h5555_AAAA);
    endtask

    task automatic t_fixed_regions(input string tag);
        step(); haddr = 32'h1000_0100; htrans = T_NSEQ; #1;
        sel_is("R4", 3'b100);
        step(); haddr = 32'h2000_FFFC; #1;
        sel_is("R5", 3'b010);
        chk("R9", {"alias data ", tag}, hrdata, rom_rdata);
        step(); htrans = T_IDLE; haddr = 32'h2000_0000; #1;
    endtask

    task automatic t_default_err();
        step(); haddr = 32'h3000_0000; htrans = T_NSEQ; #1;
        sel_is("R6", 3'b001);
        step(); htrans = T_IDLE; #1;
        chk("R6", "error cycle 1 hready", {31'd0, hready}, 32'd0);
        chk("R6", "error cycle 1 hresp", {31'd0, hresp}, 32'd1);
        step(); #1;
        chk("R6", "error cycle 2 hready", {31'd0, hready}, 32'd1);
        chk("R6", "error cycle 2 hresp", {31'd0, hresp}, 32'd1);
        step(); #1;
        chk("R6", "after error hresp", {31'd0, hresp}, 32'd0);
        // SEQ to an unmapped address also errors
        step(); haddr = 32'hFFFF_0000; htrans = T_SEQ; #1;
        step(); htrans = T_IDLE; #1;
        chk("R6", "SEQ error hready", {31'd0, hready}, 32'd0);
        chk("R6", "SEQ error hresp", {31'd0, hresp}, 32'd1);
        step(); step(); #1;
    endtask

    task automatic t_default_idle();
        step(); haddr = 32'h4000_0000; htrans = T_IDLE; #1;
        step(); htrans = T_BUSY; #1;
        chk("R7", "IDLE to default hready", {31'd0, hready}, 32'd1);
        chk("R7", "IDLE to default hresp", {31'd0, hresp}, 32'd0);
        step(); htrans = T_IDLE; #1;
        chk("R7", "BUSY to default hready", {31'd0, hready}, 32'd1);
        chk("R7", "BUSY to default hresp", {31'd0, hresp}, 32'd0);
    endtask

    // Remap write collides with a ROM wait state: must be dropped.
    task automatic t_remap_in_wait();
        step(); haddr = 32'h0000_0004; htrans = T_NSEQ; #1;
        step(); htrans = T_IDLE; rom_readyout = 1'b0; remap_we = 1'b1; remap_wdata = 1'b1; #1;
        chk("R10", "stall during write", {31'd0, hready}, 32'd0);
        step(); remap_we = 1'b0; rom_readyout = 1'b1; #1;
        step(); haddr = 32'h0000_0008; #1;
        sel_is("R10", 3'b100);
    endtask

    task automatic t_remap_set();
        step(); remap_we = 1'b1; remap_wdata = 1'b1; haddr = 32'h0000_0000; #1;
        sel_is("R2", 3'b100);
        step(); remap_we = 1'b0; #1;
        sel_is("R3", 3'b010);
        step(); haddr = 32'h0000_0000; htrans = T_NSEQ; sram_rdata = 32'hC0DE_0F00; #1;
        step(); htrans = T_IDLE; rom_readyout = 1'b0; #1;
        chk("R3", "remapped fetch ready from sram", {31'd0, hready}, 32'd1);
        chk("R3", "remapped fetch data", hrdata, 32'hC0DE_0F00);
        rom_readyout = 1'b1;
    endtask

    task automatic t_remap_clear();
        step(); remap_we = 1'b1; remap_wdata = 1'b0; #1;
        step(); remap_we = 1'b0; haddr = 32'h0000_0010; #1;
        sel_is("R11", 3'b100);
    endtask

    initial begin
        t_reset();
        t_boot_fetch();
        t_fixed_regions("boot");
        t_default_err();
        t_default_idle();
        t_remap_in_wait();
        t_remap_set();
        t_fixed_regions("remap");
        t_remap_clear();
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge hclk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule